// File: doc/BRIEF.md
# Vector Unpack and Widen Unit

This block holds a 32-entry vector register file of fixed width and executes one instruction on it: narrow elements are taken from one or two source registers, each widened to twice its width by sign or zero extension, and the results are written into a group of two or four consecutive destination registers. Every source register is treated as two halves of narrow elements. The lower-index half becomes the first destination of its pair and the upper-index half becomes the second.

A 32-bit instruction word arrives with a valid strobe. The block decodes it, and if the word matches and uses a legal size it writes the whole destination group on the next rising clock edge. A matching word with the reserved size raises the undefined flag for one cycle and writes nothing. Any other word is ignored. A write port and a combinational read port on the register file let the environment load operands and inspect results. The vector length is a parameter that must be a multiple of 128 bits.

Top module: `vunpk_top`

## Requirements
- R1: After reset every register reads as zero and `undef_insn` is low.
- R2: With `wr_en` high, `wr_data` is stored into register `wr_addr` on the rising edge. `rd_data` always shows register `rd_addr` from the current state.
- R3: The word matches only when bits 31:24 are 11000001, bit 21 is 1 and bits 19:10 are 0101111000. A valid word that fails any of these changes no register and leaves `undef_insn` low.
- R4: A matching word whose size field (bits 23:22) is 00 sets `undef_insn` during the cycle after the edge that accepts it and changes no register. `undef_insn` is low in every cycle that does not follow such a word.
- R5: Size field 01 widens 8-bit elements to 16 bits, 10 widens 16-bit elements to 32 bits, and 11 widens 32-bit elements to 64 bits. Each register holds VLEN divided by the wide width of wide elements.
- R6: Pair form (bit 20 = 0): the source is register bits 9:5 and the first destination is bits 4:1 times 2. Narrow elements 0 to E-1 of the source fill destination d, and elements E to 2E-1 fill d+1, where E is the wide element count. No other register changes.
- R7: Quad form (bit 20 = 1): the sources are n and n+1 with n = bits 9:6 times 2, and the first destination is d = bits 4:2 times 4. Source n fills d (lower half) and d+1 (upper half). Source n+1 fills d+2 and d+3 in the same way.
- R8: A quad-form word with bit 5 or bit 1 set is not a match. It changes no register and does not raise `undef_insn`.
- R9: Bit 0 clear sign-extends each narrow element. Bit 0 set zero-extends it.
- R10: All results are computed from the register contents before the edge, so they are correct when the source and destination groups overlap.
- R11: If the write port and an executing instruction target the same register in one cycle, the instruction result is stored. A write-port write to any other register still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| undef_insn | output | 1 | Reserved-size encoding was presented in the previous cycle |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | 5 | Register file write index |
| wr_data | input | VLEN | Register file write value |
| rd_addr | input | 5 | Register file read index |
| rd_data | output | VLEN | Contents of register `rd_addr` |

## Verification
The assertions check on every cycle the control-level behaviour that can be seen at the ports. They cover when the undefined flag may and must rise, that words failing the fixed opcode bits or the quad-form zero bits never raise it, and that a reserved-size word leaves a steadily watched register unchanged. Whether the widened lanes land in the right destination with the right extension, how overlapping groups behave, and which write wins on a collision can only be shown by the bench scenarios. These compare the read port against a behavioural model after every edge and against hand-computed lane values.

// File: rtl/vunpk_pkg.sv
package vunpk_pkg;

    localparam int unsigned NUM_VREGS = 32;
    localparam int unsigned VIDX_W    = 5;
    localparam int unsigned NUM_SIZES = 3;

    localparam logic [7:0] OPC_TOP = 8'b1100_0001;
    localparam logic [9:0] OPC_MID = 10'b01_0111_1000;

    typedef enum logic [1:0] {
        SZ_RSVD = 2'b00,
        SZ_H    = 2'b01,
        SZ_S    = 2'b10,
        SZ_D    = 2'b11
    } wsize_e;

    typedef struct packed {
        logic              hit;
        logic              rsvd;
        logic              quad;
        logic              zext;
        wsize_e            size;
        logic [VIDX_W-1:0] src;
        logic [VIDX_W-1:0] dst;
    } dec_t;

endpackage

// File: rtl/vunpk_decode.sv
module vunpk_decode
    import vunpk_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    logic fixed_ok;
    logic quad_clean;

    always_comb begin
        fixed_ok   = (word[31:24] == OPC_TOP) && word[21] && (word[19:10] == OPC_MID);
        quad_clean = !word[20] || (!word[5] && !word[1]);

        dec.hit  = fixed_ok && quad_clean;
        dec.rsvd = fixed_ok && quad_clean && (word[23:22] == 2'b00);
        dec.quad = word[20];
        dec.zext = word[0];
        dec.size = wsize_e'(word[23:22]);
        if (word[20]) begin
            dec.src = {word[9:6], 1'b0};
            dec.dst = {word[4:2], 2'b00};
        end else begin
            dec.src = word[9:5];
            dec.dst = {word[4:1], 1'b0};
        end
    end

endmodule

// File: rtl/vunpk_widen.sv
module vunpk_widen
    import vunpk_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic [VLEN-1:0] src,
    input  logic            upper,
    input  wsize_e          size,
    input  logic            zext,
    output logic [VLEN-1:0] dst
);

    wire [NUM_SIZES-1:0][VLEN-1:0] cand;

    generate
        for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
            localparam int unsigned WIDE   = 16 << s;
            localparam int unsigned NARROW = WIDE / 2;
            localparam int unsigned LANES  = VLEN / WIDE;
            for (genvar e = 0; e < LANES; e++) begin : g_lane
                logic [NARROW-1:0] lo_el;
                logic [NARROW-1:0] hi_el;
                logic [NARROW-1:0] pick;
                logic              fill;
                assign lo_el = src[e*NARROW +: NARROW];
                assign hi_el = src[(LANES+e)*NARROW +: NARROW];
                assign pick  = upper ? hi_el : lo_el;
                assign fill  = pick[NARROW-1] & ~zext;
                assign cand[s][e*WIDE +: WIDE] = {{NARROW{fill}}, pick};
            end
        end
    endgenerate

    always_comb begin
        case (size)
            SZ_H:    dst = cand[0];
            SZ_S:    dst = cand[1];
            SZ_D:    dst = cand[2];
            default: dst = '0;
        endcase
    end

endmodule

// File: rtl/vunpk_top.sv
module vunpk_top
    import vunpk_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn,
    output logic              undef_insn,
    input  logic              wr_en,
    input  logic [VIDX_W-1:0] wr_addr,
    input  logic [VLEN-1:0]   wr_data,
    input  logic [VIDX_W-1:0] rd_addr,
    output logic [VLEN-1:0]   rd_data
);

    localparam int unsigned GRP_MAX  = 4;
    localparam int unsigned SRC_MAX  = GRP_MAX / 2;
    localparam int unsigned GRP_PAIR = 2;

    typedef struct packed {
        logic [NUM_VREGS-1:0][VLEN-1:0] rf;
        logic                           undef;
    } state_t;

    state_t st_d;
    state_t st_q;
    dec_t   dec;
    logic   exec;

    logic [SRC_MAX-1:0][VLEN-1:0] srcv;
    wire  [GRP_MAX-1:0][VLEN-1:0] wide;

    vunpk_decode u_dec (
        .word (insn),
        .dec  (dec)
    );

    // Sources come from the registered state, so overlapping groups see old data.
    assign srcv[0] = st_q.rf[dec.src];
    assign srcv[1] = st_q.rf[dec.src | VIDX_W'(1)];

    generate
        for (genvar r = 0; r < GRP_MAX; r++) begin : g_dst
            localparam logic UPPER_HALF = (r % 2) != 0;
            vunpk_widen #(.VLEN(VLEN)) u_widen (
                .src   (srcv[r/2]),
                .upper (UPPER_HALF),
                .size  (dec.size),
                .zext  (dec.zext),
                .dst   (wide[r])
            );
        end
    endgenerate

    assign exec = insn_valid && dec.hit && !dec.rsvd;

    always_comb begin
        st_d       = st_q;
        st_d.undef = insn_valid && dec.rsvd;
        if (wr_en) begin
            st_d.rf[wr_addr] = wr_data;
        end
        if (exec) begin
            for (int r = 0; r < GRP_MAX; r++) begin
                if (r < GRP_PAIR || dec.quad) begin
                    st_d.rf[dec.dst | VIDX_W'(r)] = wide[r];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign undef_insn = st_q.undef;
    assign rd_data    = st_q.rf[rd_addr];

endmodule

// File: rtl/vunpk_chk.sv
module vunpk_chk #(
    parameter int unsigned VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            insn_valid,
    input logic [31:0]     insn,
    input logic            wr_en,
    input logic [4:0]      rd_addr,
    input logic [VLEN-1:0] rd_data,
    input logic            undef_insn
);

    logic opc_ok;
    logic quad_bad;
    logic rsvd_word;

    assign opc_ok    = (insn[31:24] == 8'hC1) && insn[21] && (insn[19:10] == 10'b0101111000);
    assign quad_bad  = insn[20] && (insn[5] || insn[1]);
    assign rsvd_word = insn_valid && opc_ok && !quad_bad && (insn[23:22] == 2'b00);

    // R4: a reserved-size match raises the flag in the next cycle
    a_r4_rsvd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_word |=> undef_insn);

    // R4: the flag is only ever a one-cycle response to a valid word
    a_r4_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !undef_insn);

    // R4: a reserved-size word changes no register
    a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsvd_word && !wr_en) |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));

    // R3: wrong fixed opcode bits never raise the flag
    a_r3_no_flag_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !opc_ok) |=> !undef_insn);

    // R8: quad form with a non-zero must-be-zero bit is not a match
    a_r8_quad_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && quad_bad) |=> !undef_insn);

    // R8: and it changes no register
    a_r8_quad_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && quad_bad && !wr_en) |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));

endmodule

bind vunpk_top vunpk_chk #(.VLEN(VLEN)) u_vunpk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn       (insn),
    .wr_en      (wr_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .undef_insn (undef_insn)
);

// File: tb/tb_vunpk_top.sv
module tb_vunpk_top;

    localparam int unsigned VLEN = 128;
    localparam int unsigned NR   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            insn_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic            undef_insn;
    logic            wr_en = 1'b0;
    logic [4:0]      wr_addr = '0;
    logic [VLEN-1:0] wr_data = '0;
    logic [4:0]      rd_addr = '0;
    logic [VLEN-1:0] rd_data;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    logic [VLEN-1:0] m_rf [NR];
    logic            m_undef;

    always #4 clk = ~clk;

    vunpk_top #(.VLEN(VLEN)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .insn       (insn),
        .undef_insn (undef_insn),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc2(input logic [1:0] sz, input logic [4:0] zn,
                                         input logic [3:0] zd, input logic u);
        return {8'hC1, sz, 1'b1, 1'b0, 10'b0101111000, zn, zd, u};
    endfunction

    function automatic logic [31:0] enc4(input logic [1:0] sz, input logic [3:0] zn,
                                         input logic [2:0] zd, input logic u);
        return {8'hC1, sz, 1'b1, 1'b1, 10'b0101111000, zn, 1'b0, zd, 1'b0, u};
    endfunction

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Behavioural reference, advanced on every rising edge.
    task automatic model_step();
        logic [VLEN-1:0] old [NR];
        bit fixed, quad, hit;
        int sz;
        old = m_rf;
        fixed = (insn[31:24] == 8'hC1) && insn[21] && (insn[19:10] == 10'b0101111000);
        quad  = insn[20];
        hit   = fixed && (!quad || (insn[5] == 1'b0 && insn[1] == 1'b0));
        sz    = int'(insn[23:22]);
        m_undef = insn_valid && hit && (sz == 0);
        if (wr_en) m_rf[wr_addr] = wr_data;
        if (insn_valid && hit && sz != 0) begin
            int es, h, lanes, nreg, n, d;
            logic [63:0] hmask, wmask;
            es    = 8 << sz;
            h     = es / 2;
            lanes = VLEN / es;
            nreg  = quad ? 4 : 2;
            n     = quad ? int'(insn[9:6]) * 2 : int'(insn[9:5]);
            d     = quad ? int'(insn[4:2]) * 4 : int'(insn[4:1]) * 2;
            hmask = (64'd1 << h) - 64'd1;
            wmask = (es == 64) ? '1 : ((64'd1 << es) - 64'd1);
            for (int r = 0; r < nreg; r++) begin
                logic [VLEN-1:0] res;
                res = '0;
                for (int e = 0; e < lanes; e++) begin
                    logic [VLEN-1:0] tmp;
                    logic [63:0] nv;
                    int idx;
                    idx = (r % 2) * lanes + e;
                    tmp = old[n + r / 2] >> (idx * h);
                    nv  = tmp[63:0] & hmask;
                    if (!insn[0] && nv[h-1]) nv = nv | ~hmask;
                    nv  = nv & wmask;
                    res = res | (VLEN'(nv) << (e * es));
                end
                m_rf[d + r] = res;
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) m_rf[i] = '0;
            m_undef = 1'b0;
        end else begin
            model_step();
        end
    end

    // Compare against the model on every clock, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " flag"}, VLEN'(undef_insn), VLEN'(m_undef));
            chk({cur_req, " read"}, rd_data, m_rf[rd_addr]);
        end
    end

    task automatic write_reg(input logic [4:0] a, input logic [VLEN-1:0] v);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk); #1;
        insn_valid = 1'b1; insn = w;
        @(negedge clk); #1;
        insn_valid = 1'b0;
    endtask

    task automatic issue_wr(input logic [31:0] w, input logic [4:0] a, input logic [VLEN-1:0] v);
        @(negedge clk); #1;
        insn_valid = 1'b1; insn = w;
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk); #1;
        insn_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, input logic [VLEN-1:0] exp, input string req);
        @(negedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        chk(req, rd_data, exp);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < NR; a++) peek(5'(a), m_rf[a], req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired during %s", cur_req);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        chk("R1 flag after reset", VLEN'(undef_insn), '0);
        for (int a = 0; a < NR; a++) peek(5'(a), '0, "R1");

        // R2: load every register through the write port
        cur_req = "R2";
        for (int a = 0; a < NR; a++) write_reg(5'(a), rnd_vec());
        sweep("R2");

        // R9, R5, R6: hand-computed lanes for byte-to-halfword
        cur_req = "R9";
        write_reg(5'd3, 128'h0000_0000_0000_00C3_0000_0000_0000_7F80);
        issue(enc2(2'b01, 5'd3, 4'd5, 1'b0));
        peek(5'd10, 128'h0000_0000_0000_0000_0000_0000_007F_FF80, "R9 sign lower");
        peek(5'd11, 128'h0000_0000_0000_0000_0000_0000_0000_FFC3, "R6 upper half");
        issue(enc2(2'b01, 5'd3, 4'd5, 1'b1));
        peek(5'd10, 128'h0000_0000_0000_0000_0000_0000_007F_0080, "R9 zero lower");
        peek(5'd11, 128'h0000_0000_0000_0000_0000_0000_0000_00C3, "R9 zero upper");

        // R7, R5: hand-computed quad form, word to doubleword
        cur_req = "R7";
        write_reg(5'd4, 128'h0000000D_0000000C_0000000B_8000000A);
        write_reg(5'd5, 128'hF0000004_00000003_00000002_00000001);
        issue(enc4(2'b11, 4'd2, 3'd3, 1'b0));
        peek(5'd12, 128'h00000000_0000000B_FFFFFFFF_8000000A, "R7 d");
        peek(5'd13, 128'h00000000_0000000D_00000000_0000000C, "R7 d+1");
        peek(5'd14, 128'h00000000_00000002_00000000_00000001, "R7 d+2");
        peek(5'd15, 128'hFFFFFFFF_F0000004_00000000_00000003, "R7 d+3");

        // R5, R6, R9: pair form across sizes and extensions
        cur_req = "R6";
        for (int s = 1; s < 4; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 3; k++) begin
                    write_reg(5'($urandom % NR), rnd_vec());
                    issue(enc2(2'(s), 5'($urandom), 4'($urandom), 1'(u)));
                end
            end
        end
        sweep("R6");

        // R5, R7, R9: quad form across sizes and extensions
        cur_req = "R7";
        for (int s = 1; s < 4; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 3; k++) begin
                    write_reg(5'($urandom % NR), rnd_vec());
                    issue(enc4(2'(s), 4'($urandom), 3'($urandom), 1'(u)));
                end
            end
        end
        sweep("R7");

        // R4: reserved size in both forms
        cur_req = "R4";
        issue(enc2(2'b00, 5'd7, 4'd2, 1'b0));
        chk("R4 flag pair", VLEN'(undef_insn), VLEN'(1));
        issue(enc4(2'b00, 4'd1, 3'd6, 1'b1));
        chk("R4 flag quad", VLEN'(undef_insn), VLEN'(1));
        @(negedge clk);
        chk("R4 flag drops", VLEN'(undef_insn), '0);
        sweep("R4");

        // R3: flip each fixed opcode bit
        cur_req = "R3";
        for (int b = 10; b < 32; b++) begin
            if (b != 20 && b != 22 && b != 23) begin
                issue(enc2(2'b10, 5'd9, 4'd8, 1'b0) ^ (32'd1 << b));
                chk("R3 no flag", VLEN'(undef_insn), '0);
            end
        end
        sweep("R3");

        // R8: quad form with must-be-zero bits set
        cur_req = "R8";
        issue(enc4(2'b01, 4'd3, 3'd1, 1'b0) | 32'h20);
        chk("R8 no flag bit5", VLEN'(undef_insn), '0);
        issue(enc4(2'b10, 4'd3, 3'd1, 1'b0) | 32'h02);
        chk("R8 no flag bit1", VLEN'(undef_insn), '0);
        issue(enc4(2'b00, 4'd3, 3'd1, 1'b0) | 32'h22);
        chk("R8 no flag rsvd", VLEN'(undef_insn), '0);
        sweep("R8");

        // R10: overlapping source and destination groups
        cur_req = "R10";
        write_reg(5'd6, 128'h8877_6655_4433_2211_F0E0_D0C0_B0A0_9080);
        issue(enc2(2'b01, 5'd6, 4'd3, 1'b0));
        peek(5'd6, 128'hFFF0_FFE0_FFD0_FFC0_FFB0_FFA0_FF90_FF80, "R10 pair overlap lower");
        peek(5'd7, 128'hFF88_0077_0066_0055_0044_0033_0022_0011, "R10 pair overlap upper");
        issue(enc4(2'b10, 4'd2, 3'd1, 1'b1));
        issue(enc4(2'b11, 4'd8, 3'd4, 1'b0));
        issue(enc2(2'b11, 5'd17, 4'd8, 1'b0));
        sweep("R10");

        // R11: write port collides with the instruction
        cur_req = "R11";
        write_reg(5'd4, 128'h0000000D_0000000C_0000000B_8000000A);
        write_reg(5'd5, 128'hF0000004_00000003_00000002_00000001);
        issue_wr(enc4(2'b11, 4'd2, 3'd3, 1'b0), 5'd12, {VLEN/8{8'hAB}});
        peek(5'd12, 128'h00000000_0000000B_FFFFFFFF_8000000A, "R11 instruction wins");
        issue_wr(enc4(2'b11, 4'd2, 3'd3, 1'b0), 5'd30, {VLEN/8{8'h5C}});
        peek(5'd30, {VLEN/8{8'h5C}}, "R11 other write lands");
        sweep("R11");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule